// File: doc/BRIEF.md
# Dual-clock FIFO with selectable overwrite mode

This block is a single-channel first-in first-out buffer of 4096 twelve-bit words. The write side and the read side each have their own clock, and each side has its own synchronous pointer reset. Write and read pointers cross between the two clock domains as Gray codes through two-flop synchronizers. As a result, a flag that depends on the far side's pointer can trail the true fill level by a few cycles of the local clock. The trailing is always in the safe direction.

The state of the enables while the resets are applied picks the operating mode. If the enables are held inactive, the FIFO is protected: a write into a full buffer and a read from an empty buffer are both dropped. If the enables are held active during the reset cycles, the FIFO runs free. Every enabled access is then performed, and the pointers wrap over unread or already-read data. This suits uses such as a circular capture buffer.

Besides the active-low full and empty flags, the block has two programmable level outputs, one registered on each clock. Their thresholds are loaded through the write data port under a load select and a threshold select.

Top module: `ovw_fifo`

## Requirements
- R1: Words leave in the order they were written. Storage holds DEPTH=4096 words of 12 bits, and both pointers wrap from address 4095 back to address 0.
- R2: In protected mode, a write with `wen_n`=0 and `ld_n`=1 is dropped while `full_n` is 0. Neither memory nor the write pointer changes.
- R3: In protected mode, a read with `ren_n`=0 is dropped while `empty_n` is 0, and `rdata` keeps the last word read until the next performed read.
- R4: In overwrite mode, every enabled write and read is performed whatever the flags show. After 4096 writes with no read, `full_n` is 0, and the next write lands at address 0, replacing the oldest unread word.
- R5: Each side latches its mode while its reset is low. The mode is overwrite if its enable (`wen_n` or `ren_n`) is 0 in any clock of that reset, and protected if the enable stays 1 throughout.
- R6: A write-clock edge with `wen_n`=0 and `ld_n`=0 copies `wdata` into a threshold register instead of memory. `thr_sel`=0 selects the high-water threshold and `thr_sel`=1 selects the low-water threshold. Neither pointer moves.
- R7: `level_ok`, registered on `rclk`, is 1 exactly when the write pointer leads the read pointer by at least N+1 words, where N is the low-water threshold.
- R8: `space_ok`, registered on `wclk`, is 1 exactly when at least N+1 locations are free, where N is the high-water threshold.
- R9: After both resets, `empty_n`=0, `full_n`=1, `level_ok`=0, `space_ok`=1 and `rdata`=0, and both thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-side pointer reset, active low, synchronous to wclk |
| wen_n | input | 1 | Write enable, active low |
| ld_n | input | 1 | Threshold load select, active low (with wen_n low) |
| thr_sel | input | 1 | Threshold select: 0 high-water, 1 low-water |
| wdata | input | 12 | Write data or threshold value |
| full_n | output | 1 | Full flag, active low |
| space_ok | output | 1 | High when free locations exceed the high-water threshold |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Read-side pointer reset, active low, synchronous to rclk |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | 12 | Registered read data |
| empty_n | output | 1 | Empty flag, active low |
| level_ok | output | 1 | High when stored words exceed the low-water threshold |

## Verification
On the write port, a threshold load and a data write compete for the same clock edge and the same bus. The bench loads thresholds with `wen_n` low on an otherwise idle FIFO. It then checks that `empty_n` stays low and that later data reads return only the words written as data. On the read side, a read and the flag that would block it fall in the same cycle once the buffer drains or overfills. The bench runs the same fill and drain in both modes. In protected mode it expects the extra access to be dropped and `rdata` held. In overwrite mode it expects the slot-0 overwrite and a stale word returned past empty.

// File: rtl/fifo_ovw_pkg.sv
package fifo_ovw_pkg;

    // operating mode chosen by the reset sequence on each side
    typedef enum logic {
        MODE_PROT = 1'b0,
        MODE_OVW  = 1'b1
    } fifo_mode_e;

    localparam int FIFO_DEPTH_DEF = 4096;
    localparam int FIFO_WIDTH_DEF = 12;

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DEPTH = 4096,
    parameter int DW    = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    logic [DW-1:0] dout_d, dout_q;

    // output word holds unless a read is performed
    always_comb begin
        dout_d = dout_q;
        if (re) begin
            dout_d = mem[raddr];
        end
        if (!rrst_n) begin
            dout_d = '0;
        end
    end

    always_ff @(posedge rclk) begin
        dout_q <= dout_d;
    end

    assign rdata = dout_q;

endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_ovw_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int DW    = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          ld_n,
    input  logic          thr_sel,
    input  logic [DW-1:0] din,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wptr,
    output logic          mode_ovw,
    output logic [DW-1:0] thr_low,
    output logic          full_n,
    output logic          space_ok
);

    localparam int CW = ((PW > DW) ? PW : DW) + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full_n;
        logic          space_ok;
        fifo_mode_e    mode;
        logic          in_rst;
        logic [DW-1:0] thr_hi;
        logic [DW-1:0] thr_lo;
    } wr_st_t;

    wr_st_t st_d, st_q;

    function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic          do_load;
    logic          do_write;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] diff;
    logic [CW-1:0] used_w;
    logic [CW-1:0] thr_w;

    always_comb begin
        st_d     = st_q;
        rbin_s   = gray2bin(rgray_s);
        do_load  = rst_n && !en_n && !ld_n;
        do_write = rst_n && !en_n && ld_n &&
                   ((st_q.mode == MODE_OVW) || st_q.full_n);

        if (do_load) begin
            if (thr_sel) begin
                st_d.thr_lo = din;
            end else begin
                st_d.thr_hi = din;
            end
        end

        if (do_write) begin
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray = bin2gray(st_d.bin);

        // flags look at the pointer after this edge's write
        diff          = st_d.bin - rbin_s;
        used_w        = {{(CW-PW){1'b0}}, diff};
        thr_w         = {{(CW-DW){1'b0}}, st_d.thr_hi};
        st_d.full_n   = (used_w < DEPTH_C);
        st_d.space_ok = ((used_w + thr_w) < DEPTH_C);
        st_d.in_rst   = 1'b0;

        if (!rst_n) begin
            st_d.bin      = '0;
            st_d.gray     = '0;
            st_d.full_n   = 1'b1;
            st_d.space_ok = 1'b1;
            st_d.thr_hi   = '0;
            st_d.thr_lo   = '0;
            st_d.in_rst   = 1'b1;
            // any reset clock with the enable active selects overwrite
            if (!en_n || (st_q.in_rst && (st_q.mode == MODE_OVW))) begin
                st_d.mode = MODE_OVW;
            end else begin
                st_d.mode = MODE_PROT;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign we       = do_write;
    assign waddr    = st_q.bin[AW-1:0];
    assign wgray    = st_q.gray;
    assign wptr     = st_q.bin;
    assign mode_ovw = (st_q.mode == MODE_OVW);
    assign thr_low  = st_q.thr_lo;
    assign full_n   = st_q.full_n;
    assign space_ok = st_q.space_ok;

endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_ovw_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int DW    = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic [PW-1:0] wgray_s,
    input  logic [DW-1:0] thr_low_s,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] rptr,
    output logic          mode_ovw,
    output logic          empty_n,
    output logic          level_ok
);

    localparam int CW = ((PW > DW) ? PW : DW) + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty_n;
        logic          level_ok;
        fifo_mode_e    mode;
        logic          in_rst;
    } rd_st_t;

    rd_st_t st_d, st_q;

    function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic          do_read;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] diff;
    logic [CW-1:0] used_w;
    logic [CW-1:0] thr_w;

    always_comb begin
        st_d    = st_q;
        wbin_s  = gray2bin(wgray_s);
        do_read = rst_n && !en_n &&
                  ((st_q.mode == MODE_OVW) || st_q.empty_n);

        if (do_read) begin
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray = bin2gray(st_d.bin);

        diff          = wbin_s - st_d.bin;
        used_w        = {{(CW-PW){1'b0}}, diff};
        thr_w         = {{(CW-DW){1'b0}}, thr_low_s};
        st_d.empty_n  = (diff != '0);
        st_d.level_ok = (used_w > thr_w);
        st_d.in_rst   = 1'b0;

        if (!rst_n) begin
            st_d.bin      = '0;
            st_d.gray     = '0;
            st_d.empty_n  = 1'b0;
            st_d.level_ok = 1'b0;
            st_d.in_rst   = 1'b1;
            if (!en_n || (st_q.in_rst && (st_q.mode == MODE_OVW))) begin
                st_d.mode = MODE_OVW;
            end else begin
                st_d.mode = MODE_PROT;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign re       = do_read;
    assign raddr    = st_q.bin[AW-1:0];
    assign rgray    = st_q.gray;
    assign rptr     = st_q.bin;
    assign mode_ovw = (st_q.mode == MODE_OVW);
    assign empty_n  = st_q.empty_n;
    assign level_ok = st_q.level_ok;

endmodule

// File: rtl/ovw_fifo.sv
module ovw_fifo
    import fifo_ovw_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH_DEF,
    parameter int DW    = FIFO_WIDTH_DEF,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wen_n,
    input  logic          ld_n,
    input  logic          thr_sel,
    input  logic [DW-1:0] wdata,
    output logic          full_n,
    output logic          space_ok,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          ren_n,
    output logic [DW-1:0] rdata,
    output logic          empty_n,
    output logic          level_ok
);

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic          mem_re;
    logic [AW-1:0] mem_raddr;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] wr_gray_s;
    logic [PW-1:0] rd_gray_s;
    logic [PW-1:0] wr_ptr_bin;
    logic [PW-1:0] rd_ptr_bin;
    logic          wr_ovw;
    logic          rd_ovw;
    logic [DW-1:0] thr_low_w;
    logic [DW-1:0] thr_low_r;

    fifo_wr_ctl #(.DEPTH(DEPTH), .DW(DW)) u_wr (
        .clk      (wclk),
        .rst_n    (wrst_n),
        .en_n     (wen_n),
        .ld_n     (ld_n),
        .thr_sel  (thr_sel),
        .din      (wdata),
        .rgray_s  (rd_gray_s),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wgray    (wr_gray),
        .wptr     (wr_ptr_bin),
        .mode_ovw (wr_ovw),
        .thr_low  (thr_low_w),
        .full_n   (full_n),
        .space_ok (space_ok)
    );

    fifo_rd_ctl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
        .clk       (rclk),
        .rst_n     (rrst_n),
        .en_n      (ren_n),
        .wgray_s   (wr_gray_s),
        .thr_low_s (thr_low_r),
        .re        (mem_re),
        .raddr     (mem_raddr),
        .rgray     (rd_gray),
        .rptr      (rd_ptr_bin),
        .mode_ovw  (rd_ovw),
        .empty_n   (empty_n),
        .level_ok  (level_ok)
    );

    fifo_sync #(.W(PW)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .din   (wr_gray),
        .dout  (wr_gray_s)
    );

    fifo_sync #(.W(PW)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .din   (rd_gray),
        .dout  (rd_gray_s)
    );

    // low-water threshold is quasi-static configuration
    fifo_sync #(.W(DW)) u_sync_thr (
        .clk   (rclk),
        .rst_n (rrst_n),
        .din   (thr_low_w),
        .dout  (thr_low_r)
    );

    fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .wclk   (wclk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wdata),
        .rclk   (rclk),
        .rrst_n (rrst_n),
        .re     (mem_re),
        .raddr  (mem_raddr),
        .rdata  (rdata)
    );

endmodule

// File: rtl/ovw_fifo_chk.sv
module ovw_fifo_chk #(
    parameter int PW = 13,
    parameter int DW = 12
) (
    input logic          wclk,
    input logic          wrst_n,
    input logic          wen_n,
    input logic          ld_n,
    input logic          full_n,
    input logic          rclk,
    input logic          rrst_n,
    input logic          ren_n,
    input logic          empty_n,
    input logic [DW-1:0] rdata,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic          wr_ovw,
    input logic          rd_ovw
);

    // R2: protected write into a full buffer leaves the pointer alone
    assert_full_blocks_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
        (!wr_ovw && !full_n && !wen_n && ld_n) |=> $stable(wr_ptr));

    // R3: protected read of an empty buffer moves nothing and holds data
    assert_empty_holds_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!rd_ovw && !empty_n && !ren_n) |=> ($stable(rd_ptr) && $stable(rdata)));

    // R6: a threshold load never advances the write pointer
    assert_load_no_move_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        (!wen_n && !ld_n) |=> $stable(wr_ptr));

    // R4: overwrite mode performs every enabled write
    assert_ovw_write_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_ovw && !wen_n && ld_n) |=> (wr_ptr == PW'($past(wr_ptr) + 1'b1)));

    // R4: overwrite mode performs every enabled read
    assert_ovw_read_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_ovw && !ren_n) |=> (rd_ptr == PW'($past(rd_ptr) + 1'b1)));

endmodule

bind ovw_fifo ovw_fifo_chk #(.PW(PW), .DW(DW)) u_chk (
    .wclk    (wclk),
    .wrst_n  (wrst_n),
    .wen_n   (wen_n),
    .ld_n    (ld_n),
    .full_n  (full_n),
    .rclk    (rclk),
    .rrst_n  (rrst_n),
    .ren_n   (ren_n),
    .empty_n (empty_n),
    .rdata   (rdata),
    .wr_ptr  (wr_ptr_bin),
    .rd_ptr  (rd_ptr_bin),
    .wr_ovw  (wr_ovw),
    .rd_ovw  (rd_ovw)
);

// File: tb/ovw_fifo_tb.sv
module ovw_fifo_tb;

    localparam int DEPTH = 4096;
    localparam int DW    = 12;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          wrst_n = 1'b0;
    logic          rrst_n = 1'b0;
    logic          wen_n = 1'b1;
    logic          ren_n = 1'b1;
    logic          ld_n = 1'b1;
    logic          thr_sel = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          full_n, space_ok, empty_n, level_ok;
    logic [DW-1:0] rdata;

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    ovw_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .wclk     (wclk),
        .wrst_n   (wrst_n),
        .wen_n    (wen_n),
        .ld_n     (ld_n),
        .thr_sel  (thr_sel),
        .wdata    (wdata),
        .full_n   (full_n),
        .space_ok (space_ok),
        .rclk     (rclk),
        .rrst_n   (rrst_n),
        .ren_n    (ren_n),
        .rdata    (rdata),
        .empty_n  (empty_n),
        .level_ok (level_ok)
    );

    int            n_chk = 0;
    int            n_err = 0;
    bit            done = 0;
    bit            ovw_mode = 0;
    logic [DW-1:0] ref_q [$];
    logic [DW-1:0] last_rd = '0;
    int            seq = 0;

    // step table: bit 15 = 1 read, 0 write; bits 11:0 = count
    localparam logic [15:0] STEPS [10] = '{
        16'h0003, 16'h8002, 16'h0006, 16'h8008, 16'h0001,
        16'h8001, 16'h000C, 16'h8005, 16'h8009, 16'h0002
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit ovw);
        @(negedge rclk);
        wrst_n = 1'b0;
        rrst_n = 1'b0;
        ld_n   = 1'b1;
        wen_n  = ovw ? 1'b0 : 1'b1;
        ren_n  = ovw ? 1'b0 : 1'b1;
        repeat (4) @(negedge rclk);
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        wen_n  = 1'b1;
        ren_n  = 1'b1;
        repeat (6) @(negedge rclk);
        ref_q.delete();
        last_rd  = '0;
        ovw_mode = ovw;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 7 + 3);
    endfunction

    // back-to-back writes of generated words; protected model drops on full
    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen_n = 1'b0;
            ld_n  = 1'b1;
            wdata = pat(seq);
            if (ovw_mode || ref_q.size() < DEPTH) ref_q.push_back(pat(seq));
            seq++;
        end
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic wr_word(input logic [DW-1:0] v);
        @(negedge wclk);
        wen_n = 1'b0;
        ld_n  = 1'b1;
        wdata = v;
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic load_thr(input logic sel, input logic [DW-1:0] v);
        @(negedge wclk);
        wen_n   = 1'b0;
        ld_n    = 1'b0;
        thr_sel = sel;
        wdata   = v;
        @(negedge wclk);
        wen_n = 1'b1;
        ld_n  = 1'b1;
    endtask

    task automatic rd_one(output logic [DW-1:0] got);
        @(negedge rclk);
        ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1;
        got = rdata;
    endtask

    // protected-mode read against the reference queue
    task automatic rd_model();
        logic [DW-1:0] got;
        logic [DW-1:0] exp;
        bit            had;
        had = (ref_q.size() != 0);
        if (had) exp = ref_q.pop_front();
        else     exp = last_rd;
        rd_one(got);
        if (had) chk("R1 fifo order", got, exp);
        else     chk("R3 held word on empty", got, exp);
        last_rd = exp;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got;

        // ---- reset state (R9)
        do_reset(1'b0);
        chk("R9 empty_n", empty_n, 1'b0);
        chk("R9 full_n", full_n, 1'b1);
        chk("R9 level_ok", level_ok, 1'b0);
        chk("R9 space_ok", space_ok, 1'b1);
        chk("R9 rdata", rdata, 12'h000);

        // ---- table walk in protected mode (R1, R3)
        for (int s = 0; s < 10; s++) begin
            if (STEPS[s][15]) begin
                for (int k = 0; k < int'(STEPS[s][11:0]); k++) rd_model();
            end else begin
                wr_burst(int'(STEPS[s][11:0]));
            end
            settle();
            chk("R1 empty flag tracks fill", empty_n, (ref_q.size() != 0));
        end

        // ---- thresholds, full and drop-on-full (R6, R7, R8, R2, R5)
        do_reset(1'b0);
        load_thr(1'b1, 12'd3);
        load_thr(1'b0, 12'd5);
        settle();
        chk("R6 load leaves fifo empty", empty_n, 1'b0);
        chk("R6 load leaves level_ok", level_ok, 1'b0);
        wr_burst(3);
        settle();
        chk("R7 level_ok at N words", level_ok, 1'b0);
        wr_burst(1);
        settle();
        chk("R7 level_ok at N+1 words", level_ok, 1'b1);
        wr_burst(DEPTH - 10);
        settle();
        chk("R8 space_ok with N+1 free", space_ok, 1'b1);
        wr_burst(1);
        settle();
        chk("R8 space_ok with N free", space_ok, 1'b0);
        chk("R2 not yet full", full_n, 1'b1);
        wr_burst(5);
        settle();
        chk("R2 full_n at 4096 words", full_n, 1'b0);
        wr_word(12'hABC);
        settle();
        chk("R2 full_n after dropped write", full_n, 1'b0);
        for (int k = 0; k < DEPTH; k++) rd_model();
        settle();
        chk("R2 drained after 4096 reads", empty_n, 1'b0);
        rd_model();

        // ---- overwrite mode wrap (R4, R5)
        do_reset(1'b1);
        ovw_mode = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wclk);
            wen_n = 1'b0;
            ld_n  = 1'b1;
            wdata = DW'(i);
        end
        @(negedge wclk);
        wen_n = 1'b1;
        settle();
        chk("R4 full_n after 4096 writes", full_n, 1'b0);
        wr_word(12'h7E1);
        settle();
        rd_one(got);
        chk("R4 slot 0 overwritten", got, 12'h7E1);
        rd_one(got);
        chk("R4 second word", got, 12'h001);

        // ---- overwrite mode read past empty is performed (R4, R5)
        do_reset(1'b1);
        wr_word(12'h123);
        settle();
        rd_one(got);
        chk("R4 first word", got, 12'h123);
        rd_one(got);
        chk("R5 read past empty performed in overwrite mode", got, 12'h001);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule